// File: doc/BRIEF.md
# Four-mode universal shift register

This block is a word-wide register whose contents are rewritten on every rising clock edge in one of four ways, picked by a 2-bit mode input. It can keep its word as it is. It can move the word one place toward the higher bit index, with a serial bit entering at bit 0. It can move the word one place toward the lower bit index, with a second serial bit entering at the top bit. It can also replace the whole word from a parallel input. The register word is always visible on the output.

A typical use is to load a word and clock it out one bit at a time, or to clock bits in one at a time and then read the full word. It can also walk a single marker bit through the word. The mode is shared by every bit, so the whole word performs one operation on each edge.

The reset input is asynchronous and active low. It clears the word at once. Its release passes through a two-stage synchronizer, so the word stays cleared for the first two rising edges after the reset input goes high.

Top module: `ushift_reg`

## Requirements
- R1: While the reset input rst_n is 0, q_out is all zeros, whatever the mode or the data inputs. Driving rst_n to 0 clears q_out at once, without waiting for a clock edge.
- R2: With mode = 2'b00 (hold), q_out is unchanged across the edge.
- R3: With mode = 2'b01 (shift up), every bit i ≥ 1 takes the old value of bit i-1, and bit 0 takes ser_lo_in.
- R4: With mode = 2'b10 (shift down), every bit i ≤ W-2 takes the old value of bit i+1, and bit W-1 takes ser_hi_in.
- R5: With mode = 2'b11 (load), q_out takes par_in in a single edge.
- R6: Each edge moves the word by exactly one position. In shift-up mode, a single 1 that enters at bit 0 is seen at bit k after k+1 edges, and it is gone after W+1 edges.
- R7: After rst_n rises, the first two rising edges leave q_out at zero in every mode. From the third edge on, the mode takes effect.
- R8: Inputs that the current mode does not select have no effect. In hold mode that is both serial inputs and par_in. In shift-up mode it is ser_hi_in and par_in. In shift-down mode it is ser_lo_in and par_in. In load mode it is both serial inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_lo_in | input | 1 | Serial bit that enters bit 0 in shift-up mode |
| ser_hi_in | input | 1 | Serial bit that enters bit W-1 in shift-down mode |
| par_in | input | W | Word that is taken in load mode |
| q_out | output | W | Current register word |

## Verification
The bench toggles the serial inputs and the parallel word that the current mode does not select. A design that let the wrong end input leak in, or that swapped the two serial inputs, would then show a corrupted end bit.

A walking single 1 exposes a chain that lets a bit race ahead, or that takes a neighbour's new value rather than its old one. Such a design would show the marker several places ahead, or would smear it across the word.

The bench also asserts reset while the contents are nonzero and checks the word with no clock edge, which catches a reset that only acts on an edge. During the two edges after release it drives shift and load modes, which catches a missing or short release synchronizer as an early change of the word. A long run of mixed modes, compared on every clock against a queue model, catches any mode decoding that is swapped.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    M_HOLD  = 2'b00,
    M_UP    = 2'b01,
    M_DOWN  = 2'b10,
    M_LOAD  = 2'b11
  } mode_e;
endpackage

// File: rtl/ushift_rst_sync.sv
// Asserts asynchronously, releases after STAGES rising edges.
module ushift_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ushift_next.sv
// Per-bit 4:1 select; the mode value is the select of every bit.
module ushift_next
  import ushift_pkg::*;
#(
  parameter int W = 4
) (
  input  mode_e          mode,
  input  logic [W-1:0]   cur,
  input  logic           ser_lo,
  input  logic           ser_hi,
  input  logic [W-1:0]   par,
  output logic [W-1:0]   nxt,
  output logic           en
);
  logic [W-1:0] from_below;
  logic [W-1:0] from_above;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_low_end
      assign from_below[i] = ser_lo;
    end else begin : g_low_mid
      assign from_below[i] = cur[i-1];
    end

    if (i == W-1) begin : g_high_end
      assign from_above[i] = ser_hi;
    end else begin : g_high_mid
      assign from_above[i] = cur[i+1];
    end

    always_comb begin
      unique case (mode)
        M_HOLD: nxt[i] = cur[i];
        M_UP:   nxt[i] = from_below[i];
        M_DOWN: nxt[i] = from_above[i];
        M_LOAD: nxt[i] = par[i];
        default: nxt[i] = cur[i];
      endcase
    end
  end

  assign en = (mode != M_HOLD);
endmodule

// File: rtl/ushift_store.sv
module ushift_store #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)  q <= '0;
    else if (en)  q <= d;
  end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         ser_lo_in,
  input  logic         ser_hi_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q_out
);
  logic         srst_n;
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         word_en;
  mode_e        mode_sel;

  assign mode_sel = mode_e'(mode);

  ushift_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ushift_next #(.W(W)) u_next (
    .mode   (mode_sel),
    .cur    (word_q),
    .ser_lo (ser_lo_in),
    .ser_hi (ser_hi_in),
    .par    (par_in),
    .nxt    (word_d),
    .en     (word_en)
  );

  ushift_store #(.W(W)) u_store (
    .clk    (clk),
    .srst_n (srst_n),
    .en     (word_en),
    .d      (word_d),
    .q      (word_q)
  );

  assign q_out = word_q;
endmodule

// File: rtl/ushift_chk.sv
module ushift_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         srst_n,
  input logic [1:0]   mode,
  input logic         ser_lo_in,
  input logic         ser_hi_in,
  input logic [W-1:0] par_in,
  input logic [W-1:0] q_out
);
  // R1: word is cleared whenever the internal reset is active
  always @(negedge clk) begin
    if (srst_n === 1'b0) begin
      a_r1_reset_clear: assert (q_out == '0);
    end
  end

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (!srst_n)
    mode == 2'b00 |=> q_out == $past(q_out));

  // R3, R8
  a_r3_shift_up: assert property (@(posedge clk) disable iff (!srst_n)
    mode == 2'b01 |=> q_out == {$past(q_out[W-2:0]), $past(ser_lo_in)});

  // R4, R8
  a_r4_shift_down: assert property (@(posedge clk) disable iff (!srst_n)
    mode == 2'b10 |=> q_out == {$past(ser_hi_in), $past(q_out[W-1:1])});

  // R5
  a_r5_load: assert property (@(posedge clk) disable iff (!srst_n)
    mode == 2'b11 |=> q_out == $past(par_in));

  // R7: at the first edge the released reset is seen, the word is still clear
  a_r7_release_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_n) |-> q_out == '0);
endmodule

bind ushift_reg ushift_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_n    (srst_n),
  .mode      (mode),
  .ser_lo_in (ser_lo_in),
  .ser_hi_in (ser_hi_in),
  .par_in    (par_in),
  .q_out     (q_out)
);

// File: tb/ushift_reg_test.sv
`timescale 1ns/1ps
module ushift_reg_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic         ser_lo_in;
  logic         ser_hi_in;
  logic [W-1:0] par_in;
  logic [W-1:0] q_out;

  int total = 0;
  int bad   = 0;
  int rel_edges = 0;
  bit model[$];

  always #5ns clk = ~clk;

  ushift_reg #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ser_lo_in(ser_lo_in),
    .ser_hi_in(ser_hi_in), .par_in(par_in), .q_out(q_out)
  );

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = model[i];
    return v;
  endfunction

  task automatic model_clear();
    model.delete();
    for (int i = 0; i < W; i++) model.push_back(1'b0);
  endtask

  task automatic check(input string tag, input logic [W-1:0] exp);
    total++;
    if (q_out !== exp) begin
      bad++;
      $display("FAIL %s: q_out=%b expected=%b", tag, q_out, exp);
    end
  endtask

  // drive inputs, take one edge, update the model, check at the falling edge
  task automatic step(input logic [1:0] m, input logic lo, input logic hi,
                      input logic [W-1:0] p, input string tag);
    mode = m; ser_lo_in = lo; ser_hi_in = hi; par_in = p;
    @(posedge clk);
    if (!rst_n) begin
      model_clear();
    end else if (rel_edges < 2) begin
      rel_edges++;
      model_clear();
    end else begin
      case (m)
        2'b01: begin model.push_front(lo); void'(model.pop_back()); end
        2'b10: begin void'(model.pop_front()); model.push_back(hi); end
        2'b11: begin
          model.delete();
          for (int i = 0; i < W; i++) model.push_back(p[i]);
        end
        default: ;
      endcase
    end
    @(negedge clk);
    check(tag, model_word());
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00: return "R2 hold";
      2'b01: return "R3 shift up";
      2'b10: return "R4 shift down";
      default: return "R5 load";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b11; ser_lo_in = 1'b1; ser_hi_in = 1'b1;
    par_in = '1;
    model_clear();
    #1ns;
    check("R1 reset at time zero", '0);
    // R1: load requested during reset is overridden
    step(2'b11, 1'b1, 1'b1, '1, "R1 reset over load");
    step(2'b01, 1'b1, 1'b1, '1, "R1 reset over shift");
    rst_n = 1'b1; rel_edges = 0;
    // R7: first two edges after release leave the word clear
    step(2'b11, 1'b1, 1'b1, 4'b1111, "R7 release edge 1");
    step(2'b01, 1'b1, 1'b0, 4'b1111, "R7 release edge 2");
    // R5 load
    step(2'b11, 1'b0, 1'b0, 4'b1010, "R5 load 1010");
    step(2'b11, 1'b1, 1'b1, 4'b0110, "R5/R8 load ignores serial");
    // R2/R8 hold with other inputs toggling
    step(2'b00, 1'b1, 1'b0, 4'b1111, "R2/R8 hold a");
    step(2'b00, 1'b0, 1'b1, 4'b0000, "R2/R8 hold b");
    step(2'b00, 1'b1, 1'b1, 4'b1001, "R2/R8 hold c");
    // R3 shift up with ser_hi toggling (R8)
    step(2'b01, 1'b1, 1'b0, 4'b0000, "R3/R8 up 1");
    step(2'b01, 1'b0, 1'b1, 4'b1111, "R3/R8 up 2");
    step(2'b01, 1'b1, 1'b0, 4'b0101, "R3/R8 up 3");
    step(2'b01, 1'b1, 1'b1, 4'b1010, "R3/R8 up 4");
    // R4 shift down with ser_lo toggling (R8)
    step(2'b11, 1'b0, 1'b0, 4'b0001, "R5 load 0001");
    step(2'b10, 1'b1, 1'b0, 4'b1111, "R4/R8 down 1");
    step(2'b10, 1'b0, 1'b1, 4'b0000, "R4/R8 down 2");
    step(2'b10, 1'b1, 1'b1, 4'b1100, "R4/R8 down 3");
    step(2'b10, 1'b0, 1'b0, 4'b0011, "R4/R8 down 4");
    // R6 walking single 1
    step(2'b11, 1'b0, 1'b0, 4'b0000, "R6 clear by load");
    step(2'b01, 1'b1, 1'b0, 4'b0000, "R6 walk enter");
    check("R6 walk at bit 0", 4'b0001);
    for (int k = 1; k <= W; k++) begin
      step(2'b01, 1'b0, 1'b0, 4'b0000, "R6 walk");
      check("R6 walk position", W'(1 << k));
    end
    // mixed modes against the queue model
    for (int n = 0; n < 300; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      step(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           W'($urandom_range(0, (1 << W) - 1)), tag_of(m));
    end
    // R1: asynchronous clear mid-run, no edge needed
    step(2'b11, 1'b0, 1'b0, 4'b1101, "R5 load 1101");
    #2ns;
    rst_n = 1'b0;
    model_clear();
    #1ns;
    check("R1 async clear without edge", '0);
    step(2'b11, 1'b1, 1'b1, 4'b1111, "R1 held reset over load");
    rst_n = 1'b1; rel_edges = 0;
    step(2'b01, 1'b1, 1'b1, 4'b1111, "R7 second release edge 1");
    step(2'b11, 1'b1, 1'b1, 4'b1111, "R7 second release edge 2");
    step(2'b01, 1'b1, 1'b0, 4'b0000, "R7/R3 first active edge");
    check("R7 active after two edges", 4'b0001);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule